// File: doc/BRIEF.md
# Time-Slotted Bus Arbitration Agent

This block is one copy of a distributed arbiter for a shared bus segment. Every master on the segment carries an identical instance with its own agent index. All instances see the same request and lock lines, hold the same configuration and run the same frame counter, so each one reaches the same decision about the next bus owner on its own, and no central arbiter exists. The local transmit logic raises a request and receives a per-word grant plus a lock flag that shows it is holding the bus.

A frame counter steps through a time frame. Slots inside the frame belong to named owners. When the counter sits inside an owned slot, only that owner may win the bus. When the counter is in time that no slot covers, the requesting agents compete, either by fixed priority or by round robin. The frame length, the slot windows, the slot owners, the competition mode and a per-owner cap on words per grant all sit in a small configuration store with several pages. The store can be written at run time. A page selection takes effect at the next frame boundary, and a resynchronisation pulse restarts the frame at once. A grant is never pre-empted. The holder keeps the bus until its request drops or its word cap runs out, even past the end of its slot. It releases the lock during its last word, so the next owner is settled in that same cycle and the two transfers run back to back.

Top module: `tdma_arb_agent`

## Requirements
- R1: After reset, grant_o, lock_o and req_o are low, the frame counter is 0, page 0 is active, and every configuration word is 0. This gives fixed priority, no slots, a frame length of 0 and a one-word cap.
- R2: The frame counter advances by one per cycle from 0 to L-1 and then wraps to 0, where L is the frame-length word at address 0 of the active page. An L of 0 or 1 holds the counter at 0.
- R3: A high resync_i forces the counter to 0 on the next cycle, and that edge counts as a frame boundary.
- R4: The page on page_sel_i becomes the active page only at a frame boundary, meaning the edge where the counter wraps or a resync occurs.
- R5: When cfg_we_i is high, cfg_wdata_i is stored at address cfg_addr_i of page cfg_page_i, and a change to the active page acts from the next cycle. Address map, where S is the slot count and N the agent count: 0 is the frame length; 1 is the mode (bit 0: 1 = round robin, 0 = fixed priority); 2+s is the start of slot s; 2+S+s is the length of slot s; 2+2S+s is the owner of slot s (top bit = slot valid, low bits = agent index); 2+3S+a is the word cap of agent a.
- R6: Slot s covers counter values from its start up to, but not including, start+length. Where slots overlap, the lowest slot index applies. Inside a covered slot only the owner can win, and if the owner is not requesting, nobody wins.
- R7: In uncovered time with mode 0, the requesting agent with the lowest index wins.
- R8: In uncovered time with mode 1, the winner is the first requesting agent after the most recent winner, in rising index order with wrap-around. The most recent winner is reset to N-1.
- R9: Arbitration takes place only while bus_lock_i is low. A holder keeps the bus against every other request and past the end of its slot.
- R10: One grant carries at most cap words, and a cap of 0 counts as 1. lock_o drops during the last word, so a new winner takes over on the next cycle with no idle cycle between.
- R11: req_o equals tx_req_i, except that it is low while lock_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req_i | input | 1 | Local transmit logic has a word to send |
| req_o | output | 1 | This agent's bit on the shared request vector |
| lock_o | output | 1 | This agent holds the bus beyond the current cycle; ORed onto the shared lock line |
| grant_o | output | 1 | Local word may be sent this cycle |
| bus_req_i | input | N_AGENTS | Shared request vector, one bit per agent |
| bus_lock_i | input | 1 | OR of all agents' lock_o |
| resync_i | input | 1 | Restart the frame at counter 0 |
| page_sel_i | input | PG_W | Page to activate at the next frame boundary |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_page_i | input | PG_W | Page written |
| cfg_addr_i | input | ADR_W | Word address within the page |
| cfg_wdata_i | input | CNT_W | Write data |

## Verification
The bench connects four agents into a full segment and looks for divergence at the edges of the schedule. It checks the first and last counter values of a slot, an owned slot whose owner is idle, and a page switch that is requested in the middle of a frame. A design with an off-by-one slot window would grant the owner one cycle early or late. A design that switched pages at once would move the slot owner before the counter wraps. The bench also checks a word cap that outlasts its slot and the hand-over that follows it. A late release would leave one dead cycle, an early one would cut the burst short, and pre-emption at the slot end would give the bus away mid-transfer. Round-robin turns that wrap past the top index are checked as well, so a pointer that fails to advance, or advances from the wrong winner, would repeat or skip an agent.

// File: rtl/tdma_arb_agent.sv
module tdma_arb_agent #(
  parameter int N_AGENTS = 4,
  parameter int AGENT_ID = 0,
  parameter int N_PAGES  = 2,
  parameter int N_SLOTS  = 4,
  parameter int CNT_W    = 8,
  localparam int AG_W    = $clog2(N_AGENTS),
  localparam int PG_W    = (N_PAGES > 1) ? $clog2(N_PAGES) : 1,
  localparam int N_WORDS = 2 + 3 * N_SLOTS + N_AGENTS,
  localparam int ADR_W   = $clog2(N_WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_req_i,
  output logic                req_o,
  output logic                lock_o,
  output logic                grant_o,
  input  logic [N_AGENTS-1:0] bus_req_i,
  input  logic                bus_lock_i,
  input  logic                resync_i,
  input  logic [PG_W-1:0]     page_sel_i,
  input  logic                cfg_we_i,
  input  logic [PG_W-1:0]     cfg_page_i,
  input  logic [ADR_W-1:0]    cfg_addr_i,
  input  logic [CNT_W-1:0]    cfg_wdata_i
);

  localparam int A_LEN   = 0;
  localparam int A_MODE  = 1;
  localparam int A_START = 2;
  localparam int A_SLEN  = 2 + N_SLOTS;
  localparam int A_OWN   = 2 + 2 * N_SLOTS;
  localparam int A_CAP   = 2 + 3 * N_SLOTS;

  logic [CNT_W-1:0] cfg_q [N_PAGES][N_WORDS];
  logic [CNT_W-1:0] act   [N_WORDS];
  logic [PG_W-1:0]  page_q;
  logic [CNT_W-1:0] cnt_q;
  logic [AG_W-1:0]  rr_q;
  logic             lock_q;
  logic [CNT_W-1:0] wcnt_q, cap_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int p = 0; p < N_PAGES; p++)
        for (int w = 0; w < N_WORDS; w++)
          cfg_q[p][w] <= '0;
    end else if (cfg_we_i && int'(cfg_addr_i) < N_WORDS) begin
      cfg_q[cfg_page_i][cfg_addr_i] <= cfg_wdata_i;
    end

  for (genvar w = 0; w < N_WORDS; w++) begin : g_act
    assign act[w] = cfg_q[page_q][w];
  end

  logic [CNT_W-1:0] flen;
  logic             mode_rr, wrap, boundary;
  assign flen     = act[A_LEN];
  assign mode_rr  = act[A_MODE][0];
  assign wrap     = (flen <= CNT_W'(1)) || (cnt_q >= flen - CNT_W'(1));
  assign boundary = wrap || resync_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q  <= '0;
      page_q <= '0;
    end else begin
      cnt_q <= boundary ? '0 : cnt_q + CNT_W'(1);
      if (boundary) page_q <= page_sel_i;
    end

  logic [N_SLOTS-1:0] hit_v;
  logic [AG_W-1:0]    own_v [N_SLOTS];

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic [CNT_W:0] lo, hi;
    assign lo       = {1'b0, act[A_START+s]};
    assign hi       = lo + {1'b0, act[A_SLEN+s]};
    assign hit_v[s] = act[A_OWN+s][CNT_W-1] && ({1'b0, cnt_q} >= lo) && ({1'b0, cnt_q} < hi);
    assign own_v[s] = act[A_OWN+s][AG_W-1:0];
  end

  logic            slot_hit;
  logic [AG_W-1:0] slot_own;
  always_comb begin
    slot_hit = 1'b0;
    slot_own = '0;
    for (int s = N_SLOTS - 1; s >= 0; s--)
      if (hit_v[s]) begin
        slot_hit = 1'b1;
        slot_own = own_v[s];
      end
  end

  logic [AG_W-1:0] pr_win, rr_win;
  always_comb begin
    pr_win = '0;
    for (int a = N_AGENTS - 1; a >= 0; a--)
      if (bus_req_i[a]) pr_win = AG_W'(a);
  end

  always_comb begin
    int j;
    rr_win = '0;
    for (int k = N_AGENTS; k >= 1; k--) begin
      j = int'(rr_q) + k;
      if (j >= N_AGENTS) j = j - N_AGENTS;
      if (bus_req_i[j]) rr_win = AG_W'(j);
    end
  end

  logic            win_vld, arb_fire, win_self;
  logic [AG_W-1:0] win;
  assign win      = slot_hit ? slot_own : (mode_rr ? rr_win : pr_win);
  assign win_vld  = slot_hit ? bus_req_i[slot_own] : |bus_req_i;
  assign arb_fire = !bus_lock_i && win_vld;
  assign win_self = arb_fire && (win == AG_W'(AGENT_ID));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rr_q <= AG_W'(N_AGENTS - 1);
    else if (arb_fire) rr_q <= win;

  logic [CNT_W-1:0] cap_raw, cap_eff;
  logic             ending;
  assign cap_raw = act[A_CAP+AGENT_ID];
  assign cap_eff = (cap_raw == '0) ? CNT_W'(1) : cap_raw;
  assign ending  = !tx_req_i || (wcnt_q == cap_q - CNT_W'(1));
  assign lock_o  = lock_q && !ending;
  assign grant_o = lock_q && tx_req_i;
  assign req_o   = tx_req_i && !lock_o;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lock_q <= 1'b0;
      wcnt_q <= '0;
      cap_q  <= CNT_W'(1);
    end else if (win_self) begin
      lock_q <= 1'b1;
      wcnt_q <= '0;
      cap_q  <= cap_eff;
    end else if (lock_q && ending) begin
      lock_q <= 1'b0;
    end else if (grant_o) begin
      wcnt_q <= wcnt_q + CNT_W'(1);
    end

  a_r9_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> !$past(bus_lock_i));

  a_r10_word_cap: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> (wcnt_q < cap_q));

  a_r4_page_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (page_q != $past(page_q)) |-> (cnt_q == '0));

  a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!resync_i && flen > CNT_W'(1) && cnt_q < flen - CNT_W'(1)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  a_r6_slot_owner_only: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lock_q) && $past(slot_hit)) |-> ($past(slot_own) == AG_W'(AGENT_ID)));

endmodule

// File: tb/test_tdma_arb_agent.sv
module test_tdma_arb_agent;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int NS = 4;
  localparam int CW = 8;
  localparam int AW = 5;
  localparam int A_CAP = 2 + 3 * NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  tx = '0, req, lock, grant;
  logic          bus_lock;
  logic          resync = 1'b0, page_sel = 1'b0;
  logic          cfg_we = 1'b0, cfg_page = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  assign bus_lock = |lock;
  always #(CLK_PERIOD / 2) clk = ~clk;

  tdma_arb_agent #(.N_AGENTS(N), .AGENT_ID(0), .N_SLOTS(NS), .CNT_W(CW)) i_tdma_arb_agent (
    .clk, .rst_n, .tx_req_i(tx[0]), .req_o(req[0]), .lock_o(lock[0]), .grant_o(grant[0]),
    .bus_req_i(req), .bus_lock_i(bus_lock), .resync_i(resync), .page_sel_i(page_sel),
    .cfg_we_i(cfg_we), .cfg_page_i(cfg_page), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata));
  tdma_arb_agent #(.N_AGENTS(N), .AGENT_ID(1), .N_SLOTS(NS), .CNT_W(CW)) i_agent1 (
    .clk, .rst_n, .tx_req_i(tx[1]), .req_o(req[1]), .lock_o(lock[1]), .grant_o(grant[1]),
    .bus_req_i(req), .bus_lock_i(bus_lock), .resync_i(resync), .page_sel_i(page_sel),
    .cfg_we_i(cfg_we), .cfg_page_i(cfg_page), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata));
  tdma_arb_agent #(.N_AGENTS(N), .AGENT_ID(2), .N_SLOTS(NS), .CNT_W(CW)) i_agent2 (
    .clk, .rst_n, .tx_req_i(tx[2]), .req_o(req[2]), .lock_o(lock[2]), .grant_o(grant[2]),
    .bus_req_i(req), .bus_lock_i(bus_lock), .resync_i(resync), .page_sel_i(page_sel),
    .cfg_we_i(cfg_we), .cfg_page_i(cfg_page), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata));
  tdma_arb_agent #(.N_AGENTS(N), .AGENT_ID(3), .N_SLOTS(NS), .CNT_W(CW)) i_agent3 (
    .clk, .rst_n, .tx_req_i(tx[3]), .req_o(req[3]), .lock_o(lock[3]), .grant_o(grant[3]),
    .bus_req_i(req), .bus_lock_i(bus_lock), .resync_i(resync), .page_sel_i(page_sel),
    .cfg_we_i(cfg_we), .cfg_page_i(cfg_page), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata));

  // {tx_req, expected grant} under fixed priority, one-word cap (R7)
  localparam logic [7:0] PRIO_VEC [7] = '{8'h11, 8'hE2, 8'hC4, 8'h88, 8'hF1, 8'hA2, 8'h00};

  task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] t, input logic [N-1:0] exp, input string tag);
    @(negedge clk);
    tx = t;
    @(posedge clk);
    #1;
    check(grant, exp, tag);
  endtask

  task automatic cfg_write(input logic pg, input int addr, input logic [CW-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_page = pg; cfg_addr = AW'(addr); cfg_wdata = data;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
  endtask

  task automatic do_resync();
    @(negedge clk);
    tx = '0;
    resync = 1'b1;
    @(posedge clk);
    #1;
    resync = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(grant, 4'b0000, "R1 grant");
    check(lock,  4'b0000, "R1 lock");
    check(req,   4'b0000, "R1 req");

    @(negedge clk);
    tx = 4'b0001;
    #1;
    check(req, 4'b0001, "R11 req follows tx");

    for (int i = 0; i < 7; i++)
      step(PRIO_VEC[i][7:4], PRIO_VEC[i][3:0], "R7 priority");

    // round robin, last winner agent 1
    cfg_write(1'b0, 1, 8'h01);
    step(4'b1111, 4'b0100, "R5 mode write / R8");
    step(4'b1111, 4'b1000, "R8");
    step(4'b1111, 4'b0001, "R8 wrap");
    step(4'b1111, 4'b0010, "R8");
    step(4'b1111, 4'b0100, "R8");
    step(4'b1001, 4'b1000, "R8 skip idle");
    step(4'b1001, 4'b0001, "R8 wrap skip");
    step(4'b1001, 4'b1000, "R8");
    step(4'b0000, 4'b0000, "R8 idle");

    // word cap 3 for agent 2
    cfg_write(1'b0, A_CAP + 2, 8'd3);
    step(4'b1100, 4'b0100, "R10 word1");
    check(lock, 4'b0100, "R10 lock held");
    check(req,  4'b1000, "R11 holder req low");
    step(4'b1100, 4'b0100, "R9 hold vs other req");
    step(4'b1100, 4'b0100, "R10 word3");
    check(lock, 4'b0000, "R10 release in last word");
    step(4'b1100, 4'b1000, "R10 back to back");
    step(4'b1100, 4'b0100, "R10 regrant");
    step(4'b0000, 4'b0000, "R10 idle");

    // frame 8, slot 0 = [2,5) owned by agent 3, priority
    cfg_write(1'b0, 1, 8'h00);
    cfg_write(1'b0, 0, 8'd8);
    cfg_write(1'b0, 2, 8'd2);
    cfg_write(1'b0, 2 + NS, 8'd3);
    cfg_write(1'b0, 2 + 2 * NS, 8'h83);
    do_resync();
    step(4'b1111, 4'b0001, "R3 cnt0");
    step(4'b1111, 4'b0001, "R6 before slot");
    step(4'b1111, 4'b1000, "R6 slot first");
    step(4'b1111, 4'b1000, "R6 slot mid");
    step(4'b1111, 4'b1000, "R6 slot last");
    step(4'b1111, 4'b0001, "R6 after slot");
    step(4'b1111, 4'b0001, "R2 cnt6");
    step(4'b1111, 4'b0001, "R2 cnt7");
    step(4'b1111, 4'b0001, "R2 wrap cnt0");
    step(4'b1111, 4'b0001, "R2 cnt1");
    step(4'b1111, 4'b1000, "R2 slot again");
    step(4'b0111, 4'b0000, "R6 owner idle");
    step(4'b0111, 4'b0000, "R6 owner idle");
    step(4'b0111, 4'b0001, "R6 free again");

    // agent 3 cap 4: transfer runs past slot end
    cfg_write(1'b0, A_CAP + 3, 8'd4);
    do_resync();
    step(4'b1001, 4'b0001, "R3 cnt0");
    step(4'b1001, 4'b0001, "R6 cnt1");
    step(4'b1001, 4'b1000, "R6 owner wins");
    step(4'b1001, 4'b1000, "R9 word2");
    step(4'b1001, 4'b1000, "R9 word3");
    check(lock, 4'b1000, "R9 lock");
    step(4'b1001, 4'b1000, "R9 word4 past slot");
    check(lock, 4'b0000, "R10 release");
    step(4'b1001, 4'b0001, "R10 handover");
    step(4'b0000, 4'b0000, "R9 idle");

    // page 1: frame 4, whole frame owned by agent 1
    cfg_write(1'b1, 0, 8'd4);
    cfg_write(1'b1, 2, 8'd0);
    cfg_write(1'b1, 2 + NS, 8'd4);
    cfg_write(1'b1, 2 + 2 * NS, 8'h81);
    do_resync();
    page_sel = 1'b1;
    step(4'b0011, 4'b0001, "R4 still page0");
    step(4'b0011, 4'b0001, "R4 still page0");
    step(4'b0011, 4'b0000, "R4 page0 slot");
    step(4'b0011, 4'b0000, "R4 page0 slot");
    step(4'b0011, 4'b0000, "R4 page0 slot");
    step(4'b0011, 4'b0001, "R4 page0 cnt5");
    step(4'b0011, 4'b0001, "R4 page0 cnt6");
    step(4'b0011, 4'b0001, "R4 page0 cnt7");
    step(4'b0011, 4'b0010, "R4 page1 active");
    step(4'b0011, 4'b0010, "R4 page1");

    page_sel = 1'b0;
    do_resync();
    step(4'b0011, 4'b0001, "R3 resync switches page");
    step(4'b0011, 4'b0001, "R3 page0 cnt1");

    summary();
  end
endmodule